// File: doc/BRIEF.md
# Byte-Lane Peripheral Address Decoder

This block sits between a processor's 32-bit address bus and a set of slow board peripherals: a boot ROM, a 2 KB non-volatile store built on an EEPROM, a four-bit real-time-clock port that shares its byte with a status nibble, and a write-only LED latch. Every transfer through it is a single byte. Read data leaves on the top byte lane of the 32-bit return bus. The decode is purely combinational, so the selected device must answer in the same cycle.

The block picks exactly one peripheral per request, or raises a single bus-error flag when the address is not mapped or the access is not allowed. It passes the device a byte offset and, on a write, a write strobe. The ROM is reachable in two windows. In one of them only lane-0 bytes may be used, and that window also accepts writes so that a ROM emulator can be loaded. A read-only alias of the clock port guards the status bits against stray writes. After each write to the store, a lockout timer blocks the store for a fixed time (20 ms by default, counted in system clock cycles) and shows a busy flag.

Top module: `lane_periph_dec`

## Requirements
- R1: At most one of `cs_rom`, `cs_store`, `cs_rtc`, `cs_led` is high. None is high when `req_valid` is low or when `bus_err` is high.
- R2: A permitted read returns its byte on `rdata[31:24]`. `rdata[23:0]` is always zero, and `rdata` is all zero on a write or on an error.
- R3: Addresses 0x1F00_0000 to 0x1F03_FFFF read the ROM with `dev_addr` = address bits [17:0]. A write in this window raises `bus_err` and gives no strobe.
- R4: When `rom_128k` is low (64 KB parts), a primary-window ROM address whose bits [17:16] are 2'b11 raises `bus_err`. When `rom_128k` is high, that range is readable.
- R5: Addresses 0xF000_0000 to 0xF002_FFFF mirror the ROM at the same 18-bit offset. Only addresses with bits [1:0] = 0 are reachable, for both reads and writes; any other byte lane raises `bus_err`.
- R6: Addresses 0xF004_0000 to 0xF005_FFFF select the store with `dev_addr` = address bits [12:2], zero-extended. Bits [16:13] and [1:0] are ignored, so the 2 KB store repeats across the window.
- R7: A write that reaches the store starts a lockout of CLK_HZ/1000*LOCK_MS cycles. `store_busy` is high for exactly that many cycles, starting in the cycle after the write.
- R8: While `store_busy` is high, any store access raises `bus_err` and gives no `cs_store`.
- R9: Addresses 0xF006_xxxx select the clock port with `dev_addr` = address bits [5:2]. A read returns the clock nibble on `rdata[31:28]` and status on `rdata[27:24]`: bit 24 = store busy, bit 25 = inverse of `pwr_fail_n`, bit 26 = `cnt_enable`, bit 27 = inverse of `sec_fail_n`.
- R10: A write to the clock port strobes the clock (`cs_rtc`, `dev_we`, byte on `dev_wdata`) and leaves the status nibble unchanged. Later reads still show the inputs.
- R11: Addresses 0xF003_xxxx are a read-only alias of the clock port and give the same data as 0xF006_xxxx. A write there raises `bus_err` and gives no strobe.
- R12: A write anywhere in 0xF007_xxxx loads `req_wdata` into `led_q` at the clock edge. `led_q` resets to 8'hFF, and a read there raises `bus_err`.
- R13: Any address outside the windows above raises `bus_err` and gives no select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rom_128k | input | 1 | Size strap: 1 = 128 KB ROM parts, 0 = 64 KB parts |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 8 | Write byte |
| rom_rdata | input | 8 | Byte returned by the ROM |
| store_rdata | input | 8 | Byte returned by the store |
| rtc_rdata | input | 4 | Nibble returned by the clock chip |
| pwr_fail_n | input | 1 | Power-fail input, active low |
| sec_fail_n | input | 1 | Secondary-fail input, active low |
| cnt_enable | input | 1 | Key-switch count-enable signal |
| cs_rom | output | 1 | ROM select |
| cs_store | output | 1 | Store select |
| cs_rtc | output | 1 | Clock port select |
| cs_led | output | 1 | LED latch select |
| dev_we | output | 1 | Write strobe for the selected device |
| dev_addr | output | 18 | Byte offset or index within the selected device |
| dev_wdata | output | 8 | Write byte to the device |
| rdata | output | 32 | Read data, byte on bits 31:24 |
| bus_err | output | 1 | Unmapped or forbidden access |
| store_busy | output | 1 | Store lockout in progress |
| led_q | output | 8 | LED latch contents |

## Verification
The properties assume that a request is held for one clock only and that the address and data stay fixed from one falling edge through the next rising edge. They also assume that the device read buses settle in the same cycle. The bench drives each request at the falling edge, samples the outputs one nanosecond later, and drops `req_valid` just after the rising edge. This way a store write is seen once and arms the lockout once. The bench builds the block with a low clock-frequency parameter so that the lockout window lasts 2000 cycles and can be counted whole. It waits for `store_busy` to clear before checking the clock status nibble.

// File: rtl/lpd_pkg.sv
package lpd_pkg;

    localparam int unsigned OFS_W = 18;

    localparam logic [13:0] ROM_PRI_HI  = 14'h07C0;   // 0x1F00_0000 >> 18
    localparam logic [13:0] ROM_MIR_HI  = 14'h3C00;   // 0xF000_0000 >> 18
    localparam logic [14:0] STORE_HI    = 15'h7802;   // 0xF004_0000 >> 17
    localparam logic [15:0] RTC_RO_HI   = 16'hF003;
    localparam logic [15:0] RTC_HI      = 16'hF006;
    localparam logic [15:0] LED_HI      = 16'hF007;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_ROM,
        RG_ROM_MIR,
        RG_STORE,
        RG_RTC,
        RG_RTC_RO,
        RG_LED
    } region_e;

    typedef enum logic [2:0] {
        TG_NONE,
        TG_ROM,
        TG_STORE,
        TG_RTC,
        TG_LED
    } target_e;

    typedef struct packed {
        region_e            region;
        logic [OFS_W-1:0]   offset;
    } decode_t;

    typedef struct packed {
        target_e            target;
        logic               err;
        logic               grant;
    } verdict_t;

    function automatic region_e classify(input logic [31:0] a);
        region_e r;
        r = RG_NONE;
        if (a[31:18] == ROM_PRI_HI)
            r = RG_ROM;
        else if (a[31:18] == ROM_MIR_HI && a[17:16] != 2'b11)
            r = RG_ROM_MIR;
        else if (a[31:16] == RTC_RO_HI)
            r = RG_RTC_RO;
        else if (a[31:17] == STORE_HI)
            r = RG_STORE;
        else if (a[31:16] == RTC_HI)
            r = RG_RTC;
        else if (a[31:16] == LED_HI)
            r = RG_LED;
        return r;
    endfunction

    function automatic logic [3:0] status_nibble(
        input logic busy, input logic pf_n, input logic cen, input logic sf_n);
        return {~sf_n, cen, ~pf_n, busy};
    endfunction

endpackage

// File: rtl/lpd_region_decode.sv
module lpd_region_decode
    import lpd_pkg::*;
(
    input  logic [31:0] addr,
    output decode_t     dec
);
    always_comb begin
        dec.region = classify(addr);
        dec.offset = addr[OFS_W-1:0];
    end
endmodule

// File: rtl/lpd_access_gate.sv
module lpd_access_gate
    import lpd_pkg::*;
#(
    parameter int unsigned STORE_BYTES = 2048,
    parameter int unsigned RTC_NIBBLES = 16
) (
    input  logic                 valid,
    input  logic                 write,
    input  logic                 rom_128k,
    input  logic                 busy,
    input  decode_t              dec,
    output verdict_t             vd,
    output logic [OFS_W-1:0]     dev_ofs
);
    localparam int unsigned SIDX_W = $clog2(STORE_BYTES);
    localparam int unsigned RIDX_W = $clog2(RTC_NIBBLES);

    logic    bad;
    target_e tgt;

    always_comb begin
        bad = 1'b0;
        tgt = TG_NONE;
        unique case (dec.region)
            RG_ROM: begin
                tgt = TG_ROM;
                bad = write || (!rom_128k && dec.offset[17:16] == 2'b11);
            end
            RG_ROM_MIR: begin
                tgt = TG_ROM;
                bad = (dec.offset[1:0] != 2'b00);
            end
            RG_STORE: begin
                tgt = TG_STORE;
                bad = busy;
            end
            RG_RTC: begin
                tgt = TG_RTC;
            end
            RG_RTC_RO: begin
                tgt = TG_RTC;
                bad = write;
            end
            RG_LED: begin
                tgt = TG_LED;
                bad = !write;
            end
            default: begin
                tgt = TG_NONE;
                bad = 1'b1;
            end
        endcase
        vd.err    = valid && bad;
        vd.grant  = valid && !bad;
        vd.target = vd.grant ? tgt : TG_NONE;
    end

    always_comb begin
        dev_ofs = '0;
        case (vd.target)
            TG_ROM:   dev_ofs = dec.offset;
            TG_STORE: dev_ofs = OFS_W'(dec.offset[SIDX_W+1:2]);
            TG_RTC:   dev_ofs = OFS_W'(dec.offset[RIDX_W+1:2]);
            default:  dev_ofs = '0;
        endcase
    end
endmodule

// File: rtl/lpd_lockout_timer.sv
module lpd_lockout_timer #(
    parameter int unsigned CLK_HZ  = 25_000_000,
    parameter int unsigned LOCK_MS = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int unsigned LOCK_CYCLES = CLK_HZ / 1000 * LOCK_MS;
    localparam int unsigned CNT_W       = $clog2(LOCK_CYCLES + 1);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (start)
            remain <= CNT_W'(LOCK_CYCLES);
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/lpd_read_mux.sv
module lpd_read_mux
    import lpd_pkg::*;
(
    input  target_e      target,
    input  logic         rd_ok,
    input  logic [7:0]   rom_byte,
    input  logic [7:0]   store_byte,
    input  logic [3:0]   rtc_nib,
    input  logic [3:0]   status,
    output logic [31:0]  rdata
);
    logic [7:0] lane;

    always_comb begin
        lane = 8'h00;
        if (rd_ok) begin
            case (target)
                TG_ROM:   lane = rom_byte;
                TG_STORE: lane = store_byte;
                TG_RTC:   lane = {rtc_nib, status};
                default:  lane = 8'h00;
            endcase
        end
        rdata = {lane, 24'h000000};
    end
endmodule

// File: rtl/lane_periph_dec.sv
module lane_periph_dec
    import lpd_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 25_000_000,
    parameter int unsigned LOCK_MS     = 20,
    parameter int unsigned STORE_BYTES = 2048,
    parameter int unsigned RTC_NIBBLES = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rom_128k,
    input  logic         req_valid,
    input  logic         req_write,
    input  logic [31:0]  req_addr,
    input  logic [7:0]   req_wdata,
    input  logic [7:0]   rom_rdata,
    input  logic [7:0]   store_rdata,
    input  logic [3:0]   rtc_rdata,
    input  logic         pwr_fail_n,
    input  logic         sec_fail_n,
    input  logic         cnt_enable,
    output logic         cs_rom,
    output logic         cs_store,
    output logic         cs_rtc,
    output logic         cs_led,
    output logic         dev_we,
    output logic [17:0]  dev_addr,
    output logic [7:0]   dev_wdata,
    output logic [31:0]  rdata,
    output logic         bus_err,
    output logic         store_busy,
    output logic [7:0]   led_q
);
    decode_t          dec;
    verdict_t         vd;
    logic [OFS_W-1:0] ofs;
    logic             busy_w;
    logic             store_wr;

    lpd_region_decode i_decode (
        .addr (req_addr),
        .dec  (dec)
    );

    lpd_access_gate #(
        .STORE_BYTES (STORE_BYTES),
        .RTC_NIBBLES (RTC_NIBBLES)
    ) i_gate (
        .valid    (req_valid),
        .write    (req_write),
        .rom_128k (rom_128k),
        .busy     (busy_w),
        .dec      (dec),
        .vd       (vd),
        .dev_ofs  (ofs)
    );

    assign store_wr = vd.grant && req_write && (vd.target == TG_STORE);

    lpd_lockout_timer #(
        .CLK_HZ  (CLK_HZ),
        .LOCK_MS (LOCK_MS)
    ) i_lock (
        .clk   (clk),
        .rst   (rst),
        .start (store_wr),
        .busy  (busy_w)
    );

    lpd_read_mux i_rmux (
        .target     (vd.target),
        .rd_ok      (vd.grant && !req_write),
        .rom_byte   (rom_rdata),
        .store_byte (store_rdata),
        .rtc_nib    (rtc_rdata),
        .status     (status_nibble(busy_w, pwr_fail_n, cnt_enable, sec_fail_n)),
        .rdata      (rdata)
    );

    always_ff @(posedge clk) begin
        if (rst)
            led_q <= 8'hFF;
        else if (vd.grant && req_write && vd.target == TG_LED)
            led_q <= req_wdata;
    end

    assign cs_rom     = (vd.target == TG_ROM);
    assign cs_store   = (vd.target == TG_STORE);
    assign cs_rtc     = (vd.target == TG_RTC);
    assign cs_led     = (vd.target == TG_LED);
    assign dev_we     = vd.grant && req_write;
    assign dev_addr   = ofs;
    assign dev_wdata  = req_wdata;
    assign bus_err    = vd.err;
    assign store_busy = busy_w;
endmodule

// File: rtl/lpd_checker.sv
module lpd_checker (
    input logic         clk,
    input logic         rst,
    input logic         rom_128k,
    input logic         req_valid,
    input logic         req_write,
    input logic [31:0]  req_addr,
    input logic         pwr_fail_n,
    input logic         cs_rom,
    input logic         cs_store,
    input logic         cs_rtc,
    input logic         cs_led,
    input logic         dev_we,
    input logic [31:0]  rdata,
    input logic         bus_err,
    input logic         store_busy,
    input logic [7:0]   led_q
);
    a_r1_cs_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cs_rom, cs_store, cs_rtc, cs_led}));

    a_r1_err_no_cs: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> !(cs_rom || cs_store || cs_rtc || cs_led));

    a_r2_low_lanes_zero: assert property (@(posedge clk) disable iff (rst)
        rdata[23:0] == 24'h0);

    a_r4_strap_hole: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_addr[31:18] == 14'h07C0 &&
         !rom_128k && req_addr[17:16] == 2'b11) |-> bus_err);

    a_r7_busy_after_write: assert property (@(posedge clk) disable iff (rst)
        (cs_store && dev_we) |=> store_busy);

    a_r8_no_store_when_busy: assert property (@(posedge clk) disable iff (rst)
        store_busy |-> !cs_store);

    a_r9_status_bits: assert property (@(posedge clk) disable iff (rst)
        (cs_rtc && !dev_we) |-> (rdata[25] == !pwr_fail_n && rdata[24] == store_busy));

    a_r11_ro_alias_write: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_addr[31:16] == 16'hF003) |-> (!dev_we && bus_err));

    a_r12_led_hold: assert property (@(posedge clk) disable iff (rst)
        !(cs_led && dev_we) |=> $stable(led_q));
endmodule

bind lane_periph_dec lpd_checker i_chk (
    .clk        (clk),
    .rst        (rst),
    .rom_128k   (rom_128k),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .pwr_fail_n (pwr_fail_n),
    .cs_rom     (cs_rom),
    .cs_store   (cs_store),
    .cs_rtc     (cs_rtc),
    .cs_led     (cs_led),
    .dev_we     (dev_we),
    .rdata      (rdata),
    .bus_err    (bus_err),
    .store_busy (store_busy),
    .led_q      (led_q)
);

// File: tb/test_lane_periph_dec.sv
module test_lane_periph_dec;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         rom_128k = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [31:0]  req_addr = '0;
    logic [7:0]   req_wdata = '0;
    logic [7:0]   rom_rdata = 8'hA5;
    logic [7:0]   store_rdata = 8'h3C;
    logic [3:0]   rtc_rdata = 4'h9;
    logic         pwr_fail_n = 1'b0;
    logic         sec_fail_n = 1'b1;
    logic         cnt_enable = 1'b1;
    logic         cs_rom, cs_store, cs_rtc, cs_led, dev_we, bus_err, store_busy;
    logic [17:0]  dev_addr;
    logic [7:0]   dev_wdata, led_q;
    logic [31:0]  rdata;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    localparam int LOCK_EXP = 2000;   // 100 kHz / 1000 * 20 ms

    logic [3:0]  s_cs;     // {rom, store, rtc, led}
    logic        s_we, s_err;
    logic [17:0] s_addr;
    logic [31:0] s_rdata;

    always #2.5 clk = ~clk;

    lane_periph_dec #(.CLK_HZ(100_000), .LOCK_MS(20)) i_lane_periph_dec (
        .clk(clk), .rst(rst), .rom_128k(rom_128k), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rom_rdata(rom_rdata), .store_rdata(store_rdata), .rtc_rdata(rtc_rdata),
        .pwr_fail_n(pwr_fail_n), .sec_fail_n(sec_fail_n), .cnt_enable(cnt_enable),
        .cs_rom(cs_rom), .cs_store(cs_store), .cs_rtc(cs_rtc), .cs_led(cs_led),
        .dev_we(dev_we), .dev_addr(dev_addr), .dev_wdata(dev_wdata), .rdata(rdata),
        .bus_err(bus_err), .store_busy(store_busy), .led_q(led_q));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [31:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        #1;
        s_cs = {cs_rom, cs_store, cs_rtc, cs_led};
        s_we = dev_we; s_err = bus_err; s_addr = dev_addr; s_rdata = rdata;
        @(posedge clk);
        #1 req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R12 reset led", {24'h0, led_q}, 32'hFF);
        chk("R7 reset busy", {31'h0, store_busy}, 32'h0);
        chk("R1 idle no cs", {28'h0, cs_rom, cs_store, cs_rtc, cs_led}, 32'h0);
        chk("R1 idle no err", {31'h0, bus_err}, 32'h0);
    endtask

    task automatic t_rom_primary;
        access(1'b0, 32'h1F03_ABCD, 8'h00);
        chk("R3 rom cs", {28'h0, s_cs}, 32'h8);
        chk("R3 rom offset", {14'h0, s_addr}, 32'h3ABCD);
        chk("R2 rom data lane", s_rdata, 32'hA500_0000);
        access(1'b1, 32'h1F00_0010, 8'h77);
        chk("R3 primary write err", {30'h0, s_err, s_we}, 32'h2);
        chk("R2 write rdata zero", s_rdata, 32'h0);
    endtask

    task automatic t_rom_strap;
        rom_128k = 1'b0;
        access(1'b0, 32'h1F03_0004, 8'h00);
        chk("R4 64k hole err", {27'h0, s_err, s_cs}, 32'h10);
        access(1'b0, 32'h1F02_FFFF, 8'h00);
        chk("R4 64k low ok", {27'h0, s_err, s_cs}, 32'h08);
        rom_128k = 1'b1;
        access(1'b0, 32'h1F03_0004, 8'h00);
        chk("R4 128k top ok", {27'h0, s_err, s_cs}, 32'h08);
    endtask

    task automatic t_rom_mirror;
        access(1'b0, 32'hF002_1234, 8'h00);
        chk("R5 mirror read", {9'h0, s_err, s_cs, s_addr}, {9'h0, 1'b0, 4'h8, 18'h21234});
        access(1'b1, 32'hF001_0008, 8'h42);
        chk("R5 mirror write", {26'h0, s_err, s_we, s_cs}, {26'h0, 2'b01, 4'h8});
        access(1'b0, 32'hF002_1235, 8'h00);
        chk("R5 odd lane err", {27'h0, s_err, s_cs}, 32'h10);
        access(1'b1, 32'hF000_0002, 8'h00);
        chk("R5 odd lane write err", {26'h0, s_err, s_we, s_cs}, 32'h20);
    endtask

    task automatic t_store;
        access(1'b0, 32'hF005_A7B5, 8'h00);
        chk("R6 store alias index", {9'h0, s_err, s_cs, s_addr}, {9'h0, 1'b0, 4'h4, 18'h001ED});
        chk("R2 store data", s_rdata, 32'h3C00_0000);
        access(1'b0, 32'hF004_07B4, 8'h00);
        chk("R6 store base index", {14'h0, s_addr}, 32'h1ED);
    endtask

    task automatic t_lockout;
        int n;
        access(1'b1, 32'hF004_0100, 8'h11);
        chk("R7 store write strobe", {27'h0, s_we, s_cs}, 32'h14);
        access(1'b0, 32'hF004_0100, 8'h00);
        chk("R8 busy read err", {27'h0, s_err, s_cs}, 32'h10);
        access(1'b1, 32'hF005_0000, 8'h22);
        chk("R8 busy write err", {26'h0, s_err, s_we, s_cs}, 32'h20);
        n = 0;
        while (store_busy && n < 5000) begin
            @(negedge clk);
            n++;
        end
        access(1'b0, 32'hF004_0000, 8'h00);
        chk("R8 store free after", {27'h0, s_err, s_cs}, 32'h04);
        access(1'b1, 32'hF004_0040, 8'h33);
        n = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (!store_busy) break;
            n++;
        end
        chk("R7 lockout length", n, LOCK_EXP);
    endtask

    task automatic t_rtc;
        access(1'b0, 32'hF006_1238, 8'h00);
        chk("R9 rtc index", {9'h0, s_err, s_cs, s_addr}, {9'h0, 1'b0, 4'h2, 18'hE});
        chk("R9 rtc nibble+status", s_rdata, 32'h9600_0000);
        access(1'b1, 32'hF006_0004, 8'h5F);
        chk("R10 rtc write strobe", {22'h0, s_we, s_cs, dev_wdata_cap}, {22'h0, 1'b1, 4'h2, 8'h5F});
        pwr_fail_n = 1'b1; sec_fail_n = 1'b0; cnt_enable = 1'b0;
        access(1'b0, 32'hF006_0004, 8'h00);
        chk("R10 status follows inputs", s_rdata, 32'h9800_0000);
        pwr_fail_n = 1'b0; sec_fail_n = 1'b1; cnt_enable = 1'b1;
    endtask

    logic [7:0] dev_wdata_cap;
    always @(posedge clk) dev_wdata_cap <= dev_wdata;

    task automatic t_ro_alias;
        access(1'b0, 32'hF003_0038, 8'h00);
        chk("R11 alias read", {27'h0, s_err, s_cs}, 32'h02);
        chk("R11 alias data", s_rdata, 32'h9600_0000);
        access(1'b1, 32'hF003_0004, 8'hAA);
        chk("R11 alias write blocked", {26'h0, s_err, s_we, s_cs}, 32'h20);
    endtask

    task automatic t_led;
        access(1'b1, 32'hF007_5550, 8'h5A);
        chk("R12 led write cs", {27'h0, s_we, s_cs}, 32'h11);
        @(negedge clk);
        chk("R12 led latched", {24'h0, led_q}, 32'h5A);
        access(1'b0, 32'hF007_0000, 8'h00);
        chk("R12 led read err", {27'h0, s_err, s_cs}, 32'h10);
        @(negedge clk);
        chk("R12 led kept", {24'h0, led_q}, 32'h5A);
        access(1'b1, 32'hF007_FFFF, 8'hC3);
        @(negedge clk);
        chk("R12 led alias", {24'h0, led_q}, 32'hC3);
    endtask

    task automatic t_unmapped;
        access(1'b0, 32'h2000_0000, 8'h00);
        chk("R13 unmapped low", {27'h0, s_err, s_cs}, 32'h10);
        access(1'b1, 32'hF008_0000, 8'h00);
        chk("R13 unmapped high", {26'h0, s_err, s_we, s_cs}, 32'h20);
        chk("R2 err rdata zero", s_rdata, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_rom_primary();
        t_rom_strap();
        t_rom_mirror();
        t_store();
        t_lockout();
        t_rtc();
        t_ro_alias();
        t_led();
        t_unmapped();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100_000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule